// File: doc/BRIEF.md
# Multiply-Divide Hazard Scoreboard

This block decides, one request at a time, whether an operation bound for a shared multiply/divide unit may issue in the current cycle. Every request carries an operation code. The scoreboard answers with accept or stall in the same cycle. For each request it also reports how many cycles pass before an integer register written from the HI/LO pair can be read. No arithmetic happens here. The unit and its HI/LO result pair are modelled only through timing.

Two saturating down-counters hold the state. The first counts the cycles during which the unit is still occupied. The second counts the cycles until HI/LO may be read by a move-from-HI/LO. A one-bit chain flag records whether the last operation to use the unit can feed a following multiply-accumulate directly through HI/LO. An accumulate that follows it then issues on the next cycle, even while the occupancy counter is still non-zero.

Top module: `mdu_hazard_sb`

## Requirements
- R1: After reset, `unit_busy` and `hilo_busy` are 0 and any request is accepted at once. This holds even when reset interrupts a divide that is still running.
- R2: Operation codes are: 0 = 32-bit multiply, 1 = 64-bit multiply, 2 = multiply-accumulate, 3 = 32-bit divide, 4 = 64-bit divide, 5 = move-to-HI/LO, 6 = move-from-HI/LO, 7 = no unit use. Code 7 is always accepted and reports a latency of 0.
- R3: A 32-bit multiply reports latency 4. A multiply, divide or move-to-HI/LO that comes the cycle after it stalls. The same request is accepted two cycles after the multiply.
- R4: A 64-bit multiply reports latency 6 and keeps other unit operations stalled for 3 cycles. A move-from-HI/LO after it stalls until 3 cycles after the multiply.
- R5: After a 32-bit divide, unit operations and move-from-HI/LO stall until 36 cycles after the divide. The divide reports latency 0.
- R6: After a 64-bit divide, unit operations stall until 72 cycles after the divide.
- R7: A multiply-accumulate reports latency 3. It is accepted on the cycle right after a 32-bit multiply, a multiply-accumulate or a move-to-HI/LO, so accumulates can issue back to back.
- R8: A move-from-HI/LO reports latency 3. It is accepted on the cycle right after a 32-bit multiply or a multiply-accumulate.
- R9: A move-to-HI/LO reports latency 0. A later accumulate may issue one cycle after it, and it occupies the unit for two cycles like a 32-bit multiply.
- R10: A multiply-accumulate that follows a 64-bit multiply or a divide gets no chaining. It stalls while the unit is occupied.
- R11: `req_accept` equals `req_valid` and not `req_stall`. With `req_valid` low, nothing stalls and no state changes. A stalled request leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_accept | output | 1 | Request issues this cycle |
| req_stall | output | 1 | Request held back this cycle |
| dest_lat | output | 4 | Cycles until the integer destination is readable, for the current code |
| unit_busy | output | 1 | Occupancy counter non-zero |
| hilo_busy | output | 1 | HI/LO readiness counter non-zero |

## Verification
Within a single cycle the block can have the occupancy counter still running while the chain flag allows a bypass. An accumulate asked for one cycle after a 32-bit multiply or a move-to-HI/LO meets both at once: it must be accepted, while a plain multiply in that same position must stall. The bench walks a table that places both cases side by side, with an accumulate after a 64-bit multiply as the counterexample that must stall. It compares accept and latency every cycle. Long divide windows are measured by polling with a waiting request and checking the exact cycle of the first accept.

// File: rtl/mdu_sb_pkg.sv
package mdu_sb_pkg;

    localparam int CNT_W = 8;
    localparam int LAT_W = 4;

    typedef enum logic [2:0] {
        OP_MUL32  = 3'd0,
        OP_MUL64  = 3'd1,
        OP_MACC   = 3'd2,
        OP_DIV32  = 3'd3,
        OP_DIV64  = 3'd4,
        OP_MTHILO = 3'd5,
        OP_MFHILO = 3'd6,
        OP_NONE   = 3'd7
    } mdu_op_e;

    typedef struct packed {
        logic             uses_unit;
        logic             chain_exempt;
        logic             sets_chain;
        logic             waits_hilo;
        logic [CNT_W-1:0] occ;
        logic [CNT_W-1:0] gap;
        logic [LAT_W-1:0] lat;
    } mdu_timing_t;

    // cycles a counter must hold after the issue cycle for a window of n
    function automatic logic [CNT_W-1:0] hold_len(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    // saturating decrement, raised to a new window when one is loaded
    function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cur,
                                                  input logic             load,
                                                  input logic [CNT_W-1:0] val);
        logic [CNT_W-1:0] dec;
        dec = (cur == '0) ? '0 : cur - 1'b1;
        if (load && (val > dec)) return val;
        return dec;
    endfunction

endpackage

// File: rtl/mdu_sb_decode.sv
module mdu_sb_decode
    import mdu_sb_pkg::*;
#(
    parameter int MUL32_OCC  = 2,
    parameter int MUL32_LAT  = 4,
    parameter int MUL64_OCC  = 3,
    parameter int MUL64_GAP  = 3,
    parameter int MUL64_LAT  = 6,
    parameter int MACC_LAT   = 3,
    parameter int MFHILO_LAT = 3,
    parameter int DIV32_CYC  = 36,
    parameter int DIV64_CYC  = 72
) (
    input  mdu_op_e     op_i,
    output mdu_timing_t tim_o
);
    always_comb begin
        tim_o = '0;
        unique case (op_i)
            OP_MUL32: begin
                tim_o.uses_unit  = 1'b1;
                tim_o.sets_chain = 1'b1;
                tim_o.occ        = CNT_W'(MUL32_OCC);
                tim_o.gap        = CNT_W'(1);
                tim_o.lat        = LAT_W'(MUL32_LAT);
            end
            OP_MUL64: begin
                tim_o.uses_unit = 1'b1;
                tim_o.occ       = CNT_W'(MUL64_OCC);
                tim_o.gap       = CNT_W'(MUL64_GAP);
                tim_o.lat       = LAT_W'(MUL64_LAT);
            end
            OP_MACC: begin
                tim_o.uses_unit    = 1'b1;
                tim_o.chain_exempt = 1'b1;
                tim_o.sets_chain   = 1'b1;
                tim_o.occ          = CNT_W'(1);
                tim_o.gap          = CNT_W'(1);
                tim_o.lat          = LAT_W'(MACC_LAT);
            end
            OP_DIV32: begin
                tim_o.uses_unit = 1'b1;
                tim_o.occ       = CNT_W'(DIV32_CYC);
                tim_o.gap       = CNT_W'(DIV32_CYC);
            end
            OP_DIV64: begin
                tim_o.uses_unit = 1'b1;
                tim_o.occ       = CNT_W'(DIV64_CYC);
                tim_o.gap       = CNT_W'(DIV64_CYC);
            end
            OP_MTHILO: begin
                tim_o.uses_unit  = 1'b1;
                tim_o.sets_chain = 1'b1;
                tim_o.occ        = CNT_W'(MUL32_OCC);
                tim_o.gap        = CNT_W'(1);
            end
            OP_MFHILO: begin
                tim_o.waits_hilo = 1'b1;
                tim_o.lat        = LAT_W'(MFHILO_LAT);
            end
            default: tim_o = '0;
        endcase
    end
endmodule

// File: rtl/mdu_sb_hazard.sv
module mdu_sb_hazard (
    input  logic valid_i,
    input  logic uses_unit_i,
    input  logic chain_exempt_i,
    input  logic waits_hilo_i,
    input  logic unit_nz_i,
    input  logic hilo_nz_i,
    input  logic chain_i,
    output logic stall_o,
    output logic accept_o
);
    logic unit_block;
    logic hilo_block;

    always_comb begin
        unit_block = uses_unit_i && unit_nz_i && !(chain_exempt_i && chain_i);
        hilo_block = waits_hilo_i && hilo_nz_i;
        stall_o    = valid_i && (unit_block || hilo_block);
        accept_o   = valid_i && !stall_o;
    end
endmodule

// File: rtl/mdu_sb_cnt.sv
module mdu_sb_cnt
    import mdu_sb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             nz_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_next(cnt_q, load_i, val_i);
    end

    assign nz_o = (cnt_q != '0);
endmodule

// File: rtl/mdu_hazard_sb.sv
module mdu_hazard_sb
    import mdu_sb_pkg::*;
#(
    parameter int MUL32_OCC  = 2,
    parameter int MUL32_LAT  = 4,
    parameter int MUL64_OCC  = 3,
    parameter int MUL64_GAP  = 3,
    parameter int MUL64_LAT  = 6,
    parameter int MACC_LAT   = 3,
    parameter int MFHILO_LAT = 3,
    parameter int DIV32_CYC  = 36,
    parameter int DIV64_CYC  = 72
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    output logic             req_accept,
    output logic             req_stall,
    output logic [LAT_W-1:0] dest_lat,
    output logic             unit_busy,
    output logic             hilo_busy
);
    localparam int N_CNT = 2;
    localparam int C_UNIT = 0;
    localparam int C_HILO = 1;

    mdu_timing_t      tim;
    logic             chain_q;
    logic [N_CNT-1:0] cnt_ld;
    logic [N_CNT-1:0] cnt_nz;
    logic [CNT_W-1:0] cnt_val [N_CNT];

    mdu_sb_decode #(
        .MUL32_OCC (MUL32_OCC),
        .MUL32_LAT (MUL32_LAT),
        .MUL64_OCC (MUL64_OCC),
        .MUL64_GAP (MUL64_GAP),
        .MUL64_LAT (MUL64_LAT),
        .MACC_LAT  (MACC_LAT),
        .MFHILO_LAT(MFHILO_LAT),
        .DIV32_CYC (DIV32_CYC),
        .DIV64_CYC (DIV64_CYC)
    ) u_dec (
        .op_i (mdu_op_e'(req_op)),
        .tim_o(tim)
    );

    mdu_sb_hazard u_haz (
        .valid_i       (req_valid),
        .uses_unit_i   (tim.uses_unit),
        .chain_exempt_i(tim.chain_exempt),
        .waits_hilo_i  (tim.waits_hilo),
        .unit_nz_i     (cnt_nz[C_UNIT]),
        .hilo_nz_i     (cnt_nz[C_HILO]),
        .chain_i       (chain_q),
        .stall_o       (req_stall),
        .accept_o      (req_accept)
    );

    always_comb begin
        cnt_ld[C_UNIT]  = req_accept && tim.uses_unit;
        cnt_ld[C_HILO]  = req_accept && tim.uses_unit;
        cnt_val[C_UNIT] = hold_len(tim.occ);
        cnt_val[C_HILO] = hold_len(tim.gap);
    end

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        mdu_sb_cnt u_cnt (
            .clk   (clk),
            .rst   (rst),
            .load_i(cnt_ld[g]),
            .val_i (cnt_val[g]),
            .nz_o  (cnt_nz[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                              chain_q <= 1'b0;
        else if (req_accept && tim.uses_unit) chain_q <= tim.sets_chain;
    end

    assign dest_lat  = tim.lat;
    assign unit_busy = cnt_nz[C_UNIT];
    assign hilo_busy = cnt_nz[C_HILO];
endmodule

// File: rtl/mdu_sb_chk.sv
module mdu_sb_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic       req_accept,
    input logic       req_stall,
    input logic [3:0] dest_lat,
    input logic       unit_busy,
    input logic       hilo_busy
);
    logic plain_unit_op;
    logic chain_src;
    assign plain_unit_op = (req_op == 3'd0) || (req_op == 3'd1) || (req_op == 3'd3) ||
                           (req_op == 3'd4) || (req_op == 3'd5);
    assign chain_src     = (req_op == 3'd0) || (req_op == 3'd2) || (req_op == 3'd5);

    AST_ACCEPT_XOR_STALL: assert property (@(posedge clk) disable iff (rst)
        !(req_accept && req_stall)); // R11
    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!req_stall && !req_accept)); // R11
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!unit_busy && !hilo_busy)); // R1
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (unit_busy && req_valid && plain_unit_op) |-> !req_accept); // R3
    AST_HILO_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (hilo_busy && req_valid && req_op == 3'd6) |-> !req_accept); // R4
    AST_MUL64_LAT: assert property (@(posedge clk) disable iff (rst)
        (req_accept && req_op == 3'd1) |-> dest_lat == 4'd6); // R4
    AST_DIV_OCCUPIES: assert property (@(posedge clk) disable iff (rst)
        (req_accept && (req_op == 3'd3 || req_op == 3'd4)) |=> unit_busy); // R5
    AST_MACC_CHAIN: assert property (@(posedge clk) disable iff (rst)
        ($past(req_accept && chain_src) && req_valid && req_op == 3'd2) |-> req_accept); // R7
    AST_NONE_FREE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd7) |-> (req_accept && dest_lat == 4'd0)); // R2
endmodule

bind mdu_hazard_sb mdu_sb_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_accept(req_accept),
    .req_stall (req_stall),
    .dest_lat  (dest_lat),
    .unit_busy (unit_busy),
    .hilo_busy (hilo_busy)
);

// File: tb/mdu_hazard_sb_tb.sv
`timescale 1ns/1ps
module mdu_hazard_sb_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd7;
    logic       req_accept;
    logic       req_stall;
    logic [3:0] dest_lat;
    logic       unit_busy;
    logic       hilo_busy;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mdu_hazard_sb dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_accept(req_accept), .req_stall(req_stall), .dest_lat(dest_lat),
        .unit_busy(unit_busy), .hilo_busy(hilo_busy)
    );

    // {valid, op, expected accept, expected latency}
    localparam int NV = 17;
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 3'd0, 1'b1, 4'd4},  // 0  mul32              R3
        {1'b1, 3'd0, 1'b0, 4'd4},  // 1  mul32 stalls       R3
        {1'b1, 3'd0, 1'b1, 4'd4},  // 2  mul32 issues       R3
        {1'b1, 3'd6, 1'b1, 4'd3},  // 3  mfhilo next cycle  R8
        {1'b1, 3'd2, 1'b1, 4'd3},  // 4  macc               R7
        {1'b1, 3'd2, 1'b1, 4'd3},  // 5  macc back to back  R7
        {1'b1, 3'd2, 1'b1, 4'd3},  // 6  macc               R7
        {1'b1, 3'd1, 1'b1, 4'd6},  // 7  mul64              R4
        {1'b1, 3'd6, 1'b0, 4'd3},  // 8  mfhilo waits       R4
        {1'b1, 3'd2, 1'b0, 4'd3},  // 9  macc no chain      R10
        {1'b1, 3'd6, 1'b1, 4'd3},  // 10 mfhilo at +3       R4
        {1'b1, 3'd5, 1'b1, 4'd0},  // 11 mthilo             R9
        {1'b1, 3'd2, 1'b1, 4'd3},  // 12 macc after mthilo  R9
        {1'b0, 3'd0, 1'b0, 4'd4},  // 13 idle               R11
        {1'b1, 3'd5, 1'b1, 4'd0},  // 14 mthilo             R9
        {1'b1, 3'd0, 1'b0, 4'd4},  // 15 mul32 after mthilo R9
        {1'b1, 3'd7, 1'b1, 4'd0}   // 16 no unit use        R2
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op);
        @(posedge clk);
        #1;
        req_valid = v;
        req_op    = op;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_reset;
        @(posedge clk);
        #1;
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    // first cycle offset at which op is accepted, polled every cycle
    task automatic wait_accept(input logic [2:0] op, input int lim, output int first);
        first = -1;
        for (int k = 1; k <= lim; k++) begin
            step(1'b1, op);
            if (req_accept && first < 0) first = k;
            if (first >= 0) break;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int first;
        do_reset();
        @(negedge clk);
        chk(!unit_busy, "R1 unit_busy after reset", int'(unit_busy), 0);
        chk(!hilo_busy, "R1 hilo_busy after reset", int'(hilo_busy), 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][8], VEC[i][7:5]);
            chk(req_accept == VEC[i][4], $sformatf("vector %0d accept (R2..R11)", i),
                int'(req_accept), int'(VEC[i][4]));
            chk(dest_lat == VEC[i][3:0], $sformatf("vector %0d latency (R2..R11)", i),
                int'(dest_lat), int'(VEC[i][3:0]));
            if (!VEC[i][8])
                chk(!req_stall, "R11 no stall when idle", int'(req_stall), 0);
        end
        step(1'b0, 3'd7);
        step(1'b0, 3'd7);

        // R5: 32-bit divide, move-from waits 36 cycles
        step(1'b1, 3'd3);
        chk(req_accept, "R5 div32 accepted", int'(req_accept), 1);
        chk(dest_lat == 4'd0, "R5 div32 latency", int'(dest_lat), 0);
        wait_accept(3'd6, 40, first);
        chk(first == 36, "R5 mfhilo after div32 offset", first, 36);
        step(1'b1, 3'd0);
        chk(req_accept, "R5 mul32 after div32 window", int'(req_accept), 1);
        step(1'b0, 3'd7);
        step(1'b0, 3'd7);

        // R6 / R10: 64-bit divide, accumulate waits 72 cycles
        step(1'b1, 3'd4);
        chk(req_accept, "R6 div64 accepted", int'(req_accept), 1);
        wait_accept(3'd2, 80, first);
        chk(first == 72, "R6 R10 macc after div64 offset", first, 72);
        step(1'b0, 3'd7);
        step(1'b0, 3'd7);

        // R1: reset during a running divide
        step(1'b1, 3'd4);
        step(1'b1, 3'd0);
        chk(!req_accept, "R1 mul32 stalls before reset", int'(req_accept), 0);
        do_reset();
        @(negedge clk);
        chk(!unit_busy, "R1 unit_busy cleared mid-divide", int'(unit_busy), 0);
        step(1'b1, 3'd0);
        chk(req_accept, "R1 mul32 accepted after reset", int'(req_accept), 1);
        step(1'b0, 3'd7);

        finish_run();
    end
endmodule